// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a synchronous requester and an asynchronous DRAM whose address pins carry half a word address at a time. The requester offers a full address, a direction bit and write data on a valid/ready port. The sequencer splits the address into an upper row part and a lower column part. It presents the row part with the active-low row strobe and then the column part with the active-low column strobe, and it returns read data with a one-cycle valid pulse.

After an access the row is left open. A later request to the same row costs only a new column-strobe pulse. A request to another row first closes the row and waits out the precharge time. A free-running interval timer raises a refresh request. Once the current access has finished, that request takes priority over new accesses and is served with a column-before-row strobe sequence, so the DRAM steps its own internal row counter. All timing values are counted in clock cycles and set by parameters.

Top module: `dramc_top`

## Requirements
- R1: `reqAddr` is split as row = upper half and column = lower half. `dramAddr` carries the row half when `dramRasN` falls for an access and the column half when `dramCasN` falls.
- R2: Both strobes are active low. During reset `dramRasN` and `dramCasN` are 1 and `rspValid` is 0.
- R3: The first column-strobe fall after an access row-strobe fall comes exactly T_RCD cycles after it.
- R4: A read returns the addressed word on `rspData` with `rspValid` high for exactly one cycle. The pulse rises T_RD cycles after the column strobe falls.
- R5: For a write, `dramWeN` is 0 and `dramDoe` is 1 while the column strobe is low. `dramAddr` holds steady for as long as the column strobe stays low.
- R6: A request to the currently open row produces only a new column-strobe fall, with no row-strobe edge.
- R7: Before the row strobe falls again, it has been high for at least T_RP cycles. This covers a row change and the start of a refresh.
- R8: Refresh is column-before-row: the column strobe falls while the row strobe is high, and the row strobe falls on the next cycle. Refreshes recur at least once every REF_INTERVAL cycles plus the worst access latency.
- R9: A pending refresh lowers `reqReady` until the refresh has started. A requester that keeps `reqValid` high cannot hold off refresh.
- R10: An access starts only on a cycle with `reqValid` and `reqReady` both high. With no request, the only row-strobe falls are refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Full word address, row in upper half |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle read-data pulse |
| rspData | output | DATA_W | Read data |
| dramAddr | output | ADDR_W/2 | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramDout | output | DATA_W | Data toward the DRAM |
| dramDoe | output | 1 | Data output enable |
| dramDin | input | DATA_W | Data from the DRAM |

## Verification
The hardest case to reach from the ports is a refresh timer expiring while a requester streams back-to-back accesses to the open row. In that case the refresh can be starved unless it wins arbitration as soon as the current column pulse ends. The bench holds `reqValid` high on one row for several refresh intervals and counts the column-before-row sequences that appear. A behavioural DRAM on the pins time-stamps every strobe edge, which shows whether each access opened a row or reused the open page, checked against the row history and any refresh in between.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  // strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic rasLow;    // hold row strobe asserted
    logic casLow;    // hold column strobe asserted
    logic colPhase;  // column access in progress (column address, write drive)
    logic load;      // capture the accepted request
    logic sample;    // sample read data from the DRAM
  } ctrlStrobes_t;
endpackage

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 3,
  parameter int T_RD         = 2,
  parameter int T_RP         = 3,
  parameter int REF_INTERVAL = 780
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         rowHit,
  output logic         reqReady,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(T_RCD + T_CAS + T_RP + 2);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);
  localparam logic [CNT_W-1:0] RCD_END = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] CAS_END = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0] RD_AT   = CNT_W'(T_RD);
  localparam logic [CNT_W-1:0] RP_END  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] REF_END = CNT_W'(T_RCD + T_CAS - 1);
  localparam logic [REF_W-1:0] TICK_AT = REF_W'(REF_INTERVAL - 1);

  typedef enum logic [2:0] {IDLE, ACT, COL, OPEN, PRE, REF_C, REF_R} seqState_e;

  seqState_e state, nextState;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refTimer;
  logic refPending, hasJob, accept, refTick;

  assign refTick  = (refTimer == TICK_AT);
  assign reqReady = ((state == IDLE) || (state == OPEN)) && !refPending;
  assign accept   = reqValid && reqReady;

  always_comb begin
    nextState = state;
    unique case (state)
      IDLE:  if (refPending) nextState = REF_C;
             else if (accept) nextState = ACT;
      ACT:   if (cnt == RCD_END) nextState = COL;
      COL:   if (cnt == CAS_END) nextState = OPEN;
      OPEN:  if (refPending) nextState = PRE;
             else if (accept) nextState = rowHit ? COL : PRE;
      PRE:   if (cnt == RP_END) begin
               if (hasJob) nextState = ACT;
               else if (refPending) nextState = REF_C;
               else nextState = IDLE;
             end
      REF_C: nextState = REF_R;
      REF_R: if (cnt == REF_END) nextState = PRE;
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= IDLE;
      cnt        <= '0;
      refTimer   <= '0;
      refPending <= 1'b0;
      hasJob     <= 1'b0;
    end else begin
      state    <= nextState;
      cnt      <= (nextState != state) ? '0 : cnt + 1'b1;
      refTimer <= refTick ? '0 : refTimer + 1'b1;
      if (refTick) refPending <= 1'b1;
      else if (state == REF_C) refPending <= 1'b0;
      if (state == OPEN && accept && !rowHit) hasJob <= 1'b1;
      else if (state == PRE && nextState == ACT) hasJob <= 1'b0;
    end
  end

  always_comb begin
    strobes.rasLow   = (state == ACT) || (state == COL) || (state == OPEN) || (state == REF_R);
    strobes.casLow   = (state == COL) || (state == REF_C) || (state == REF_R);
    strobes.colPhase = (state == COL);
    strobes.load     = accept;
    strobes.sample   = (state == COL) && (cnt == RD_AT);
  end
endmodule

// File: rtl/dramc_path.sv
module dramc_path
  import dramc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rowHit,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic [ADDR_W/2-1:0] dramAddr,
  output logic                dramRasN,
  output logic                dramCasN,
  output logic                dramWeN,
  output logic [DATA_W-1:0]   dramDout,
  output logic                dramDoe,
  input  logic [DATA_W-1:0]   dramDin
);
  localparam int HALF_W = ADDR_W / 2;

  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capWdata;
  logic              capWrite;
  logic [HALF_W-1:0] rowPart, colPart;

  assign rowPart = capAddr[ADDR_W-1 -: HALF_W];
  assign colPart = capAddr[HALF_W-1:0];
  assign rowHit  = (reqAddr[ADDR_W-1 -: HALF_W] == rowPart);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr  <= '0;
      capWdata <= '0;
      capWrite <= 1'b0;
    end else if (strobes.load) begin
      capAddr  <= reqAddr;
      capWdata <= reqWdata;
      capWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dramAddr <= '0;
      dramRasN <= 1'b1;
      dramCasN <= 1'b1;
      dramWeN  <= 1'b1;
      dramDout <= '0;
      dramDoe  <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      dramAddr <= strobes.colPhase ? colPart : rowPart;
      dramRasN <= !strobes.rasLow;
      dramCasN <= !strobes.casLow;
      dramWeN  <= !(strobes.colPhase && capWrite);
      dramDoe  <= strobes.colPhase && capWrite;
      dramDout <= capWdata;
      rspValid <= strobes.sample && !capWrite;
      if (strobes.sample && !capWrite) rspData <= dramDin;
    end
  end
endmodule

// File: rtl/dramc_top.sv
module dramc_top
  import dramc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 3,
  parameter int T_RD         = 2,
  parameter int T_RP         = 3,
  parameter int REF_INTERVAL = 780
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic [ADDR_W/2-1:0] dramAddr,
  output logic                dramRasN,
  output logic                dramCasN,
  output logic                dramWeN,
  output logic [DATA_W-1:0]   dramDout,
  output logic                dramDoe,
  input  logic [DATA_W-1:0]   dramDin
);
  ctrlStrobes_t strobes;
  logic rowHit;

  dramc_seq #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RD(T_RD), .T_RP(T_RP),
    .REF_INTERVAL(REF_INTERVAL)
  ) uSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .reqReady(reqReady), .strobes(strobes)
  );

  dramc_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rowHit(rowHit), .rspValid(rspValid), .rspData(rspData),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramDout(dramDout), .dramDoe(dramDoe),
    .dramDin(dramDin)
  );
endmodule

// File: rtl/dramc_chk.sv
module dramc_chk #(
  parameter int ADDR_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 3,
  parameter int T_RP         = 3,
  parameter int REF_INTERVAL = 780
) (
  input logic                clk,
  input logic                rstN,
  input logic                dramRasN,
  input logic                dramCasN,
  input logic                dramWeN,
  input logic                dramDoe,
  input logic [ADDR_W/2-1:0] dramAddr,
  input logic                rspValid
);
  localparam int LIMIT = REF_INTERVAL + 2 * T_RP + T_RCD + T_CAS + 8;

  logic [15:0] rasLowCnt, rasHighCnt;
  logic [31:0] refAge;
  logic casQ, rasQ, cbrStart;

  assign cbrStart = !dramCasN && casQ && dramRasN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasLowCnt  <= '0;
      rasHighCnt <= 16'(T_RP);
      refAge     <= '0;
      casQ       <= 1'b1;
      rasQ       <= 1'b1;
    end else begin
      casQ       <= dramCasN;
      rasQ       <= dramRasN;
      rasLowCnt  <= dramRasN ? '0 : ((rasLowCnt == 16'hFFFF) ? rasLowCnt : rasLowCnt + 1'b1);
      rasHighCnt <= !dramRasN ? '0 : ((rasHighCnt == 16'hFFFF) ? rasHighCnt : rasHighCnt + 1'b1);
      refAge     <= cbrStart ? '0 : refAge + 1'b1;
    end
  end

  a_r3_rcd_gap: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasN && casQ && !dramRasN) |-> (rasLowCnt >= 16'(T_RCD)));

  a_r7_precharge: assert property (@(posedge clk) disable iff (!rstN)
    (!dramRasN && rasQ) |-> (rasHighCnt >= 16'(T_RP)));

  a_r8_cbr_order: assert property (@(posedge clk) disable iff (!rstN)
    cbrStart |=> !dramRasN);

  a_r8_refresh_bound: assert property (@(posedge clk) disable iff (!rstN)
    refAge <= 32'(LIMIT));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasN && !casQ) |-> $stable(dramAddr));

  a_r5_write_drive: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> (dramDoe && !dramCasN));
endmodule

bind dramc_top dramc_chk #(
  .ADDR_W(ADDR_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
  .REF_INTERVAL(REF_INTERVAL)
) uChk (
  .clk(clk), .rstN(rstN), .dramRasN(dramRasN), .dramCasN(dramCasN),
  .dramWeN(dramWeN), .dramDoe(dramDoe), .dramAddr(dramAddr),
  .rspValid(rspValid)
);

// File: tb/sim_dramc_top.sv
`timescale 1ns/1ps
module sim_dramc_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int HALF_W = ADDR_W / 2;
  localparam int T_RCD = 2, T_CAS = 3, T_RD = 2, T_RP = 3;
  localparam int REF_INTERVAL = 300;
  localparam real PER = 5.0;
  localparam int NVEC = 11;
  // {write, addr, wdata, expected read}
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b1, 8'h12, 16'hA1A1, 16'h0000},
    {1'b1, 8'h15, 16'hB2B2, 16'h0000},
    {1'b0, 8'h12, 16'h0000, 16'hA1A1},
    {1'b1, 8'h37, 16'hC3C3, 16'h0000},
    {1'b0, 8'h15, 16'h0000, 16'hB2B2},
    {1'b0, 8'h37, 16'h0000, 16'hC3C3},
    {1'b1, 8'h3F, 16'hD4D4, 16'h0000},
    {1'b0, 8'h3F, 16'h0000, 16'hD4D4},
    {1'b0, 8'h30, 16'h0000, 16'h0000},
    {1'b1, 8'hFF, 16'h5A5A, 16'h0000},
    {1'b0, 8'hFF, 16'h0000, 16'h5A5A}
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqReady, rspValid, dramRasN, dramCasN, dramWeN, dramDoe;
  logic [DATA_W-1:0] rspData, dramDout, dramDin;
  logic [HALF_W-1:0] dramAddr;

  always #2.5 clk = ~clk;

  dramc_top #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RD(T_RD), .T_RP(T_RP), .REF_INTERVAL(REF_INTERVAL)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramDout(dramDout), .dramDoe(dramDoe), .dramDin(dramDin)
  );

  // behavioural DRAM
  logic [DATA_W-1:0] mem [1 << ADDR_W];
  logic [HALF_W-1:0] rowL = '0, colL = '0;
  int actCnt = 0, refCnt = 0, cbrCnt = 0, casCnt = 0;
  int rcdBad = 0, rpBad = 0, weBad = 0, latBad = 0;
  int refAtPrevCol = 0;
  bit firstCol = 0, lastPage = 0, refBetween = 0;
  realtime tRasFall = 0, tRasRise = 0, tCasFall = 0;

  initial for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;

  assign dramDin = (!dramCasN && dramWeN) ? mem[{rowL, colL}] : '0;

  always @(posedge dramRasN) tRasRise = $realtime;

  always @(negedge dramRasN) begin
    realtime t;
    t = $realtime;
    #1;
    if ((t - tRasRise) < T_RP * PER - 0.1) rpBad++;
    if (!dramCasN) refCnt++;
    else begin
      actCnt++;
      rowL = dramAddr;
      tRasFall = t;
      firstCol = 1;
    end
  end

  always @(negedge dramCasN) begin
    realtime t;
    t = $realtime;
    #1;
    if (dramRasN) cbrCnt++;
    else begin
      colL = dramAddr;
      casCnt++;
      tCasFall = t;
      if (firstCol && ((t - tRasFall) > T_RCD * PER + 0.1 || (t - tRasFall) < T_RCD * PER - 0.1)) rcdBad++;
      lastPage = !firstCol;
      firstCol = 0;
      refBetween = (refCnt != refAtPrevCol);
      refAtPrevCol = refCnt;
      if (!dramWeN) begin
        if (!dramDoe) weBad++;
        mem[{rowL, colL}] = dramDout;
      end
    end
  end

  int checks = 0, failures = 0;
  longint cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic issue(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    logic [HALF_W-1:0] prevRow;
    bit anyPrev;
    int c0, a0, r0, accepts, resp, badData;
    anyPrev = 0;
    prevRow = '0;
    repeat (6) @(negedge clk);
    // R2: reset state
    chk(dramRasN === 1'b1, "R2 rasN in reset", dramRasN, 1);
    chk(dramCasN === 1'b1, "R2 casN in reset", dramCasN, 1);
    chk(rspValid === 1'b0, "R2 rspValid in reset", rspValid, 0);
    rstN = 1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [40:0] e;
      logic [DATA_W-1:0] got;
      bit seen, expPage;
      e = VEC[v];
      c0 = casCnt;
      issue(e[40], e[39:32], e[31:16]);
      seen = 0;
      got = '0;
      for (int w = 0; w < 60 && !seen; w++) begin
        if (!e[40] && rspValid) begin
          seen = 1;
          got = rspData;
          if ($rtoi(($realtime - tCasFall) / PER) != T_RD) latBad++;
          @(negedge clk);
          chk(!rspValid, "R4 rspValid one cycle", rspValid, 0);
        end else if (e[40] && w == 14) seen = 1;
        else @(negedge clk);
      end
      chk(casCnt - c0 == 1, "R10 one column access per request", casCnt - c0, 1);
      chk({rowL, colL} == e[39:32], "R1 row/column halves", {rowL, colL}, e[39:32]);
      if (!e[40]) begin
        chk(seen, "R4 read response arrives", seen, 1);
        chk(got == e[15:0], "R4 read data", got, e[15:0]);
      end
      expPage = anyPrev && (prevRow == e[39:36]) && !refBetween;
      chk(lastPage == expPage, expPage ? "R6 page hit keeps row" : "R7 row reopened", lastPage, expPage);
      prevRow = e[39:36];
      anyPrev = 1;
    end

    // idle: only refresh
    a0 = actCnt; r0 = refCnt;
    repeat (2 * REF_INTERVAL + 60) @(negedge clk);
    chk(actCnt == a0, "R10 no access without request", actCnt - a0, 0);
    chk(refCnt - r0 >= 2, "R8 refresh recurs while idle", refCnt - r0, 2);
    chk(cbrCnt == refCnt, "R8 column strobe before row strobe", cbrCnt, refCnt);

    // streaming reads on one row: refresh must still win
    r0 = refCnt; accepts = 0; resp = 0; badData = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = 8'h37;
    for (int k = 0; k < 3 * REF_INTERVAL; k++) begin
      @(negedge clk);
      if (reqReady) accepts++;
      if (rspValid) begin
        resp++;
        if (rspData != 16'hC3C3) badData++;
      end
    end
    reqValid = 0;
    repeat (30) @(negedge clk);
    chk(refCnt - r0 >= 2, "R9 refresh not starved by stream", refCnt - r0, 2);
    chk(accepts > 0 && resp > 0, "R9 stream makes progress", resp, accepts);
    chk(badData == 0, "R4 stream read data", badData, 0);

    chk(rcdBad == 0, "R3 row-to-column gap", rcdBad, 0);
    chk(rpBad == 0, "R7 precharge time", rpBad, 0);
    chk(latBad == 0, "R4 read latency", latBad, 0);
    chk(weBad == 0, "R5 write data driven", weBad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule